// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the clocked half-duplex mode of a classic byte-wide serial port. The port moves one byte at a time over a single data line, and the block drives the shift clock on a separate line. Software controls the block through a small register port with one address bit. Address 0 is the data buffer and address 1 is the control/status register.

Writing a byte to the data buffer while the port is idle starts a transmission. A control write can also start a reception: it must enable reception while the receive flag is clear, at a moment when that condition was not already true. Each bit occupies one shift-clock period of twelve system clocks. The clock line is low for the first ten clocks of a period and high for the last two. Outgoing data changes only at the start of a period. Incoming data is captured at the clock's rising edge.

When the eighth bit finishes, the block raises a transmit flag or a receive flag. That flag stays set until software writes the control register.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data line is not driven (dataOe low), both flags are 0, and the control register reads 0.
- R2: A write to address 0 while idle sends the written byte on dataOut, bit 0 first, as eight shift-clock pulses whose rising edges are exactly 12 system clocks apart, with dataOe high for the whole transfer.
- R3: Each transmitted bit is on dataOut for 10 system clocks before the shift-clock rising edge that carries it, and it stays unchanged for 2 system clocks after that edge.
- R4: The transmit flag rises 96 system clocks after the clock edge that accepts the data write. The shift clock is then high and dataOe is low.
- R5: A control write whose value has bit 2 (receive enable) = 1 and bit 1 (receive flag) = 0 starts a reception, provided the port is idle and that condition was false before the write. The port then keeps dataOe low, captures dataIn at each of eight shift-clock rising edges (the first captured bit becomes bit 0), and returns the byte on reads of address 0.
- R6: The receive flag rises 96 system clocks after the clock edge that accepts the starting control write.
- R7: dataIn needs no hold time. A change half a system clock after a rising edge does not alter the captured bit.
- R8: While a transfer is active, a write to address 0 is ignored and a control write does not start a reception.
- R9: The flags are only cleared by a control write. Reads of address 1 return bit 0 = transmit flag, bit 1 = receive flag, bit 2 = receive enable, and zeros above.
- R10: A control write that leaves receive enable at 0 starts no reception: the shift clock stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 data buffer, 1 control/status |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for the selected address |
| sclkOut | output | 1 | Shift clock, idle high |
| dataOut | output | 1 | Serial data driven during transmission |
| dataOe | output | 1 | Drive enable for the data line (high only while transmitting) |
| dataIn | input | 1 | Serial data received from the line |
| txFlag | output | 1 | Transmit-complete flag |
| rxFlag | output | 1 | Receive-complete flag |

## Verification
Transmission is tried with the bytes A5, 3C, 01, 80, FF and 00. The alternating patterns show bit order and per-bit timing. The single-bit bytes show whether the first or the last slot is misplaced. The all-ones and all-zeros bytes show that the setup and hold windows come from the shift clock rather than from data transitions. Reception is tried with 96 and 4B. The incoming line is scrambled right after every rising edge, which separates sampling at the edge from sampling later in the period. Further runs cover a second data write and a receive-start write during a transfer, and a control write with reception disabled. These show whether the guards against restarting and false starts are in place.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Per-cycle strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;      // capture the write data for transmission
    logic shiftOut;  // advance to the next outgoing bit
    logic sampleIn;  // capture the incoming bit at the rising edge
    logic finish;    // last clock of the last bit slot
    logic txMode;    // current transfer direction
  } sspStrobe_t;

endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int BITS   = 8,
  parameter int PERIOD = 12,
  parameter int HOLD   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       addr,
  input  logic       wrTi,
  input  logic       wrRi,
  input  logic       wrRen,
  output sspStrobe_t stb,
  output logic       busy,
  output logic       sclkOut,
  output logic       dataOe,
  output logic       txFlag,
  output logic       rxFlag,
  output logic       rxEn
);

  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [PW-1:0] LAST_PH   = PW'(PERIOD - 1);
  localparam logic [PW-1:0] RISE_PH   = PW'(PERIOD - HOLD);
  localparam logic [PW-1:0] SAMPLE_PH = PW'(PERIOD - HOLD - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

  logic [PW-1:0] phase;
  logic [BW-1:0] bitCnt;
  logic          txMode;
  logic          ctlWr, startTx, startRx, slotEnd, lastSlot;

  always_comb begin
    ctlWr    = wrEn && addr;
    startTx  = wrEn && !addr && !busy;
    // reception begins when the enable-and-flag-clear condition becomes true
    startRx  = ctlWr && !busy && !(rxEn && !rxFlag) && (wrRen && !wrRi);
    slotEnd  = busy && (phase == LAST_PH);
    lastSlot = slotEnd && (bitCnt == LAST_BIT);

    stb.load     = startTx;
    stb.shiftOut = slotEnd && txMode && !lastSlot;
    stb.sampleIn = busy && !txMode && (phase == SAMPLE_PH);
    stb.finish   = lastSlot;
    stb.txMode   = txMode;
  end

  // Bit-slot sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      txMode <= 1'b0;
      phase  <= '0;
      bitCnt <= '0;
    end else if (startTx || startRx) begin
      busy   <= 1'b1;
      txMode <= startTx;
      phase  <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (slotEnd) begin
        phase <= '0;
        if (lastSlot) begin
          busy <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // Status and control bits; hardware completion wins over a same-cycle write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txFlag <= 1'b0;
      rxFlag <= 1'b0;
      rxEn   <= 1'b0;
    end else begin
      if (ctlWr) begin
        txFlag <= wrTi;
        rxFlag <= wrRi;
        rxEn   <= wrRen;
      end
      if (lastSlot && txMode)  txFlag <= 1'b1;
      if (lastSlot && !txMode) rxFlag <= 1'b1;
    end
  end

  assign sclkOut = !busy || (phase >= RISE_PH);
  assign dataOe  = busy && txMode;

endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sspStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataIn,
  output logic              dataOut,
  output logic [DATA_W-1:0] rxBuf
);

  logic [DATA_W-1:0] shiftReg;

  // One register serves both directions, always moving toward bit 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.load) begin
      shiftReg <= wrData;
    end else if (stb.shiftOut) begin
      shiftReg <= shiftReg >> 1;
    end else if (stb.sampleIn) begin
      shiftReg <= {dataIn, shiftReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (stb.finish && !stb.txMode) begin
      rxBuf <= shiftReg;
    end
  end

  assign dataOut = shiftReg[0];

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PERIOD = 12,
  parameter int HOLD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sclkOut,
  output logic              dataOut,
  output logic              dataOe,
  input  logic              dataIn,
  output logic              txFlag,
  output logic              rxFlag
);

  localparam int CTL_BITS = 3;

  sspStrobe_t        stb;
  logic              busy;
  logic              rxEn;
  logic [DATA_W-1:0] rxBuf;

  ssp_ctrl #(
    .BITS  (DATA_W),
    .PERIOD(PERIOD),
    .HOLD  (HOLD)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrTi   (wrData[0]),
    .wrRi   (wrData[1]),
    .wrRen  (wrData[2]),
    .stb    (stb),
    .busy   (busy),
    .sclkOut(sclkOut),
    .dataOe (dataOe),
    .txFlag (txFlag),
    .rxFlag (rxFlag),
    .rxEn   (rxEn)
  );

  ssp_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .dataIn (dataIn),
    .dataOut(dataOut),
    .rxBuf  (rxBuf)
  );

  assign rdData = addr ? {{(DATA_W-CTL_BITS){1'b0}}, rxEn, rxFlag, txFlag} : rxBuf;

endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic addr,
  input logic sclkOut,
  input logic dataOe,
  input logic dataOut,
  input logic txFlag,
  input logic busy
);

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && (dataOut != $past(dataOut))) |-> ($past(sclkOut) && !sclkOut));

  // R3
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $rose(sclkOut)) |-> $stable(dataOut));

  // R2
  period_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sclkOut);

  // R2
  drive_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(wrEn && !addr));

  // R4
  idle_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(sclkOut) && sclkOut && !dataOe));

  // R4
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txFlag) |-> ($fell(busy) || $past(wrEn && addr)));

  // R9
  tx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txFlag) |-> $past(wrEn && addr));

endmodule

bind sync_shift_port sync_shift_port_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .sclkOut(sclkOut),
  .dataOe (dataOe),
  .dataOut(dataOut),
  .txFlag (txFlag),
  .busy   (busy)
);

// File: tb/sync_shift_port_test.sv
`timescale 1ns/1ps
module sync_shift_port_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sclkOut, dataOut, dataOe, txFlag, rxFlag;
  logic       dataIn = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] txQ[$];

  sync_shift_port uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .sclkOut(sclkOut), .dataOut(dataOut), .dataOe(dataOe),
    .dataIn(dataIn), .txFlag(txFlag), .rxFlag(rxFlag)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  // Monitor: timing of every bit and byte comparison against the scoreboard
  logic       prevSclk = 1'b1, prevOe = 1'b0, heldBit = 1'b0;
  int         lowCnt = 0, hiCnt = 0, bitIdx = 0, lastRise = 0, cyc = 0;
  logic [7:0] capByte = 8'h00;

  always @(negedge clk) begin
    logic [7:0] expByte;
    cyc++;
    if (rstN && dataOe) begin
      if (!prevOe) begin bitIdx = 0; hiCnt = -1; end
      if (prevSclk && !sclkOut) begin
        if (prevOe) check(hiCnt == 2, "R3", "hold clocks", hiCnt, 2);
        lowCnt = 0;
      end else if (!sclkOut) begin
        lowCnt++;
      end
      if (!prevSclk && sclkOut) begin
        check(lowCnt == 9, "R3", "setup clocks", lowCnt + 1, 10);
        if (bitIdx > 0) check(cyc - lastRise == 12, "R2", "shift period", cyc - lastRise, 12);
        lastRise = cyc;
        heldBit = dataOut;
        hiCnt = 1;
        if (bitIdx < 8) capByte[bitIdx] = dataOut;
        bitIdx++;
        if (bitIdx == 8) begin
          if (txQ.size() == 0) begin
            check(1'b0, "R8", "unexpected transfer", capByte, 0);
          end else begin
            expByte = txQ.pop_front();
            check(capByte == expByte, "R2", "sent byte", capByte, expByte);
          end
        end
      end else if (sclkOut && prevSclk && prevOe) begin
        hiCnt++;
        check(dataOut == heldBit, "R3", "bit held after rise", dataOut, heldBit);
      end
    end else if (rstN && prevOe) begin
      check(hiCnt == 2, "R3", "last bit hold", hiCnt, 2);
      check(bitIdx == 8, "R2", "pulse count", bitIdx, 8);
    end
    prevSclk = sclkOut;
    prevOe = dataOe;
  end

  // Line driver for reception; scrambles the line right after each rise (R7)
  logic       rxDrive = 1'b0, prevSclkR = 1'b1;
  logic [7:0] rxPat = 8'h00;
  int         rxIdx = 0;

  always @(negedge clk) begin
    if (rxDrive && !dataOe) begin
      if (prevSclkR && !sclkOut && rxIdx < 8) begin
        dataIn = rxPat[rxIdx];
        rxIdx++;
      end else if (!prevSclkR && sclkOut && rxIdx > 0) begin
        dataIn = ~rxPat[rxIdx-1];
      end
    end
    prevSclkR = sclkOut;
  end

  task automatic txByte(input logic [7:0] b);
    int n;
    writeReg(1'b1, 8'h00);
    txQ.push_back(b);
    writeReg(1'b0, b);
    n = 0;
    while (!txFlag && n < 1000) begin @(negedge clk); n++; end
    check(n == 96, "R4", "clocks to transmit flag", n, 96);
    check(sclkOut == 1'b1 && dataOe == 1'b0, "R4", "idle after transmit", {sclkOut, dataOe}, 2);
  endtask

  task automatic rxByte(input logic [7:0] b);
    int n;
    bit oeSeen;
    logic [7:0] v;
    rxPat = b; rxIdx = 0; rxDrive = 1'b1;
    writeReg(1'b1, 8'h04);
    n = 0; oeSeen = 1'b0;
    while (!rxFlag && n < 1000) begin
      @(negedge clk); n++;
      if (dataOe) oeSeen = 1'b1;
    end
    check(n == 96, "R6", "clocks to receive flag", n, 96);
    check(!oeSeen, "R5", "line not driven while receiving", oeSeen, 0);
    readReg(1'b0, v);
    check(v == b, "R5", "received byte (R7 scrambled line)", v, b);
    readReg(1'b1, v);
    check(v == 8'h06, "R9", "control after receive", v, 8'h06);
    rxDrive = 1'b0;
  endtask

  task automatic quietFor(input int cycles, input string req);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!sclkOut) lows++;
    end
    check(lows == 0, req, "shift clock stayed idle", lows, 0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(sclkOut == 1'b1, "R1", "shift clock after reset", sclkOut, 1);
    check(dataOe == 1'b0, "R1", "line drive after reset", dataOe, 0);
    check(txFlag == 1'b0 && rxFlag == 1'b0, "R1", "flags after reset", {txFlag, rxFlag}, 0);
    rstN = 1'b1;
    readReg(1'b1, v);
    check(v == 8'h00, "R1", "control after reset", v, 0);

    // R2 R3 R4 transmit patterns
    txByte(8'hA5);
    txByte(8'h3C);
    txByte(8'h01);
    txByte(8'h80);
    txByte(8'hFF);
    txByte(8'h00);

    // R9 flag persists until a control write
    repeat (40) @(negedge clk);
    check(txFlag == 1'b1, "R9", "transmit flag persists", txFlag, 1);
    readReg(1'b1, v);
    check(v == 8'h01, "R9", "control read with transmit flag", v, 8'h01);
    writeReg(1'b1, 8'h00);
    check(txFlag == 1'b0, "R9", "transmit flag cleared by write", txFlag, 0);

    // R8 writes during an active transfer
    txQ.push_back(8'hC3);
    writeReg(1'b0, 8'hC3);
    repeat (30) @(negedge clk);
    writeReg(1'b0, 8'h5A);
    writeReg(1'b1, 8'h04);
    for (int i = 0; i < 1000 && !txFlag; i++) @(negedge clk);
    check(txFlag == 1'b1, "R8", "first transfer completed", txFlag, 1);
    quietFor(150, "R8");
    check(rxFlag == 1'b0, "R8", "no reception started", rxFlag, 0);
    check(txQ.size() == 0, "R8", "scoreboard drained", txQ.size(), 0);

    // R5 R6 R7 reception
    writeReg(1'b1, 8'h00);
    rxByte(8'h96);
    rxByte(8'h4B);

    // R10 reception disabled
    writeReg(1'b1, 8'h02);
    writeReg(1'b1, 8'h00);
    quietFor(150, "R10");
    check(rxFlag == 1'b0, "R10", "no receive flag while disabled", rxFlag, 0);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule